// File: doc/BRIEF.md
# Extended-Format Address Generator

This unit sits between instruction fetch and operand fetch of a 24-bit accumulator machine whose instructions are 1 to 4 bytes long. It takes the raw instruction, the start address of that instruction and the contents of the base and index registers. From these it decodes the instruction length and the addressing mode. It then returns the target address, or, when the mode is immediate, the operand value itself. Older programs that use the short 15-bit direct layout are still accepted, so legacy code runs unchanged.

In indirect mode the computed address points to a 3-byte word in memory, and that word holds the final target. The unit issues one read request for that word, gathers the three returned bytes and reports the result afterwards. All other modes finish one cycle after the instruction is presented. Illegal flag combinations raise an error flag and never touch memory. The unit accepts a new instruction only while no indirect read is pending.

Top module: `agu_xe_top`

## Requirements
- R1: The instruction arrives on `instr` with its first byte in bits 31:24. The length comes from the upper nibble of the first byte: C..F gives 1 byte, 9..B gives 2 bytes. Otherwise the layout is n=bit 25, i=bit 24, x=bit 23, b=bit 22, p=bit 21, e=bit 20. With n=i=0 the length is 3 bytes. With e=1 it is 4 bytes, and otherwise 3 bytes.
- R2: For 1-byte and 2-byte instructions `target` is 0, `imm_op` is 0 and `err` is 0, and no memory read is issued.
- R3: With n=i=0 (legacy layout), `target` is the 15-bit field in bits 22:8, zero-extended, plus the index register when x=1.
- R4: In a 3-byte instruction with b=1 and p=0, `target` is the base register plus the unsigned 12-bit displacement in bits 19:8.
- R5: With b=0 and p=1, `target` is the instruction start plus the length plus the sign-extended 12-bit displacement.
- R6: With b=p=0, `target` is the 12-bit displacement in a 3-byte instruction, or the 20-bit field in bits 19:0 in a 4-byte instruction. With x=1 and n=i=1, the index register is added in either case.
- R7: With n=0 and i=1, `imm_op` is 1, `target` carries the computed value and no memory read is issued.
- R8: With n=1 and i=0, exactly one `rd_req` pulse is issued, carrying the computed address on `rd_addr`. Three bytes then arrive on `rd_valid`/`rd_data`, most significant byte first. `target` becomes bits 19:0 of that word, and `done` is raised the cycle after the third byte.
- R9: Every computed address wraps modulo 2^20.
- R10: Some combinations are illegal: b=p=1, x=1 together with immediate or indirect mode, and e=1 together with b or p. Each raises `err` with `imm_op`=0 and issues no read. `target` is then unspecified.
- R11: After reset all outputs are 0. For every case other than a legal indirect one, `done` pulses exactly one cycle after `in_valid`. The results stay on the outputs until the next instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction and register values are valid; ignored while an indirect read is pending |
| instr | input | 32 | Instruction bytes, first byte in 31:24 |
| pc | input | 20 | Start address of the instruction |
| base_reg | input | 24 | Base register contents |
| index_reg | input | 24 | Index register contents |
| rd_req | output | 1 | One-cycle pulse requesting a 3-byte word |
| rd_addr | output | 20 | Address of the requested word |
| rd_valid | input | 1 | A returned byte is present |
| rd_data | input | 8 | Returned byte |
| done | output | 1 | One-cycle result strobe |
| instr_len | output | 3 | Instruction length in bytes |
| target | output | 20 | Target address or immediate value |
| imm_op | output | 1 | Target is the operand itself |
| err | output | 1 | Illegal flag combination |

## Verification
On every cycle, the assertions check several timing properties. A non-indirect instruction always finishes on the next cycle with no read. An indirect request is a single pulse, and `done` never arrives before its third byte. A completed result always reports a length from 1 to 4, and an error never comes with the immediate flag. Only the scoreboard scenarios can show that the arithmetic is right. Those scenarios cover base, PC-relative, direct, indexed, long-format and legacy addresses, wrap-around at 2^20, and the word assembled from the returned bytes, including a read that crosses the top of memory.

// File: rtl/agu_xe_pkg.sv
package agu_xe_pkg;
   typedef enum logic [1:0] {FMT_ONE, FMT_TWO, FMT_LEGACY, FMT_EXT} fmt_e;
   typedef enum logic [1:0] {AM_SIMPLE, AM_IMM, AM_INDIR} amode_e;

   typedef struct packed {
      fmt_e   fmt;
      amode_e mode;
      logic   fx;
      logic   fb;
      logic   fp;
      logic   fe;
      logic [2:0] len;
      logic   illegal;
   } dec_t;
endpackage

// File: rtl/agu_fmt_decode.sv
module agu_fmt_decode
   import agu_xe_pkg::*;
#(
   parameter int LONG_W = 20,
   parameter logic [3:0] ONE_NIB_MIN = 4'hC,
   parameter logic [3:0] TWO_NIB_MIN = 4'h9,
   localparam int INSTR_W = LONG_W + 12
) (
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);
   localparam int N_POS = LONG_W + 5;

   logic [3:0] nib;
   logic [1:0] ni;

   assign nib = instr[INSTR_W-1 -: 4];
   assign ni  = instr[N_POS -: 2];

   always_comb begin
      dec         = '0;
      dec.fx      = instr[N_POS-2];
      dec.fb      = instr[N_POS-3];
      dec.fp      = instr[N_POS-4];
      dec.fe      = instr[N_POS-5];
      dec.mode    = AM_SIMPLE;
      if (nib >= ONE_NIB_MIN) begin
         dec.fmt = FMT_ONE;
         dec.len = 3'd1;
      end else if (nib >= TWO_NIB_MIN) begin
         dec.fmt = FMT_TWO;
         dec.len = 3'd2;
      end else if (ni == 2'b00) begin
         dec.fmt = FMT_LEGACY;
         dec.len = 3'd3;
      end else begin
         dec.fmt = FMT_EXT;
         dec.len = dec.fe ? 3'd4 : 3'd3;
         if (ni == 2'b01)      dec.mode = AM_IMM;
         else if (ni == 2'b10) dec.mode = AM_INDIR;
         dec.illegal = (dec.fb & dec.fp)
                     | (dec.fx & (ni != 2'b11))
                     | (dec.fe & (dec.fb | dec.fp));
      end
   end

   always_comb begin
      assert_len_range_R1: assert (dec.len >= 3'd1 && dec.len <= 3'd4);
   end
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
   import agu_xe_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int REG_W    = 24,
   parameter int DISP_W   = 12,
   parameter int LONG_W   = 20,
   parameter int LEGACY_W = 15,
   localparam int INSTR_W = LONG_W + 12
) (
   input  dec_t               dec,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  pc,
   input  logic [REG_W-1:0]   base_reg,
   input  logic [REG_W-1:0]   index_reg,
   output logic [ADDR_W-1:0]  ea
);
   logic [DISP_W-1:0]   disp;
   logic [LONG_W-1:0]   long_f;
   logic [LEGACY_W-1:0] legacy_f;
   logic [ADDR_W-1:0]   disp_u, disp_s, next_pc, pre, idx;
   logic                unused_bits;

   assign disp     = instr[LONG_W-1 -: DISP_W];
   assign long_f   = instr[LONG_W-1:0];
   assign legacy_f = instr[LONG_W+2 -: LEGACY_W];
   assign disp_u   = ADDR_W'(disp);
   assign disp_s   = ADDR_W'($signed(disp));
   assign next_pc  = pc + ADDR_W'(dec.len);
   assign idx      = index_reg[ADDR_W-1:0];
   assign unused_bits = ^{instr[INSTR_W-1:LONG_W+3], base_reg, index_reg};

   always_comb begin
      pre = '0;
      case (dec.fmt)
         FMT_LEGACY: pre = ADDR_W'(legacy_f);
         FMT_EXT: begin
            if (dec.fe)      pre = ADDR_W'(long_f);
            else if (dec.fb) pre = base_reg[ADDR_W-1:0] + disp_u;
            else if (dec.fp) pre = next_pc + disp_s;
            else             pre = disp_u;
         end
         default: pre = '0;
      endcase
   end

   assign ea = (dec.fx && (dec.fmt == FMT_LEGACY || dec.fmt == FMT_EXT)) ? pre + idx : pre;

   always_comb begin
      if (dec.fmt == FMT_ONE || dec.fmt == FMT_TWO)
         assert_short_zero_R2: assert (ea == '0);
   end
endmodule

// File: rtl/agu_word_fetch.sv
module agu_word_fetch #(
   parameter int ADDR_W     = 20,
   parameter int WORD_BYTES = 3,
   localparam int CNT_W     = $clog2(WORD_BYTES),
   localparam int WORD_W    = 8 * WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              rd_valid,
   input  logic [7:0]        rd_data,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic              last,
   output logic [WORD_W-1:0] word
);
   logic [CNT_W-1:0] cnt;
   logic             take;

   assign take = busy & rd_valid;
   assign last = take & (cnt == CNT_W'(WORD_BYTES-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_req  <= 1'b0;
         rd_addr <= '0;
         busy    <= 1'b0;
         cnt     <= '0;
      end else begin
         rd_req <= 1'b0;
         if (start) begin
            rd_req  <= 1'b1;
            rd_addr <= start_addr;
            busy    <= 1'b1;
            cnt     <= '0;
         end else if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (take) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   for (genvar k = 0; k < WORD_BYTES - 1; k++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            lane_q <= '0;
         else if (take && cnt == CNT_W'(k))     lane_q <= rd_data;
      end
      assign word[WORD_W-1-8*k -: 8] = lane_q;
   end
   assign word[7:0] = rd_data;

   assert_single_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
   assert_req_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);
endmodule

// File: rtl/agu_xe_top.sv
module agu_xe_top
   import agu_xe_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int REG_W      = 24,
   parameter int DISP_W     = 12,
   parameter int LONG_W     = 20,
   parameter int LEGACY_W   = 15,
   parameter int WORD_BYTES = 3,
   localparam int INSTR_W   = LONG_W + 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  pc,
   input  logic [REG_W-1:0]   base_reg,
   input  logic [REG_W-1:0]   index_reg,
   output logic               rd_req,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic               rd_valid,
   input  logic [7:0]         rd_data,
   output logic               done,
   output logic [2:0]         instr_len,
   output logic [ADDR_W-1:0]  target,
   output logic               imm_op,
   output logic               err
);
   localparam int WORD_W = 8 * WORD_BYTES;

   if (LEGACY_W != DISP_W + 3) begin : g_bad_legacy
      $error("legacy field must span the displacement plus three flag bits");
   end
   if (REG_W < ADDR_W) begin : g_bad_reg
      $error("registers narrower than the address space");
   end
   if (WORD_W < ADDR_W || WORD_BYTES < 2) begin : g_bad_word
      $error("indirect word cannot hold an address");
   end
   if (LONG_W > ADDR_W || DISP_W >= ADDR_W) begin : g_bad_field
      $error("address fields wider than the address space");
   end

   dec_t              dec;
   logic [ADDR_W-1:0] ea;
   logic              busy, last, accept, start;
   logic [WORD_W-1:0] word;

   agu_fmt_decode #(.LONG_W(LONG_W)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   agu_ea_calc #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .DISP_W(DISP_W),
      .LONG_W(LONG_W), .LEGACY_W(LEGACY_W)
   ) u_ea (
      .dec       (dec),
      .instr     (instr),
      .pc        (pc),
      .base_reg  (base_reg),
      .index_reg (index_reg),
      .ea        (ea)
   );

   assign accept = in_valid & ~busy;
   assign start  = accept & (dec.mode == AM_INDIR) & ~dec.illegal;

   agu_word_fetch #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_addr (ea),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .busy       (busy),
      .last       (last),
      .word       (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         instr_len <= '0;
         target    <= '0;
         imm_op    <= 1'b0;
         err       <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            instr_len <= dec.len;
            err       <= dec.illegal;
            imm_op    <= (dec.mode == AM_IMM) & ~dec.illegal;
            if (!start) begin
               target <= ea;
               done   <= 1'b1;
            end
         end else if (last) begin
            target <= word[ADDR_W-1:0];
            done   <= 1'b1;
         end
      end
   end

   assert_quick_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !busy && !start) |=> done);
   assert_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !busy && !start) |=> !rd_req);
   assert_wait_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> !done);
   assert_err_not_imm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> !imm_op);
   assert_done_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (instr_len >= 3'd1 && instr_len <= 3'd4));
endmodule

// File: tb/agu_xe_top_tb.sv
module agu_xe_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [19:0] pc = '0;
   logic [23:0] base_reg = '0;
   logic [23:0] index_reg = '0;
   logic        rd_req;
   logic [19:0] rd_addr;
   logic        rd_valid = 1'b0;
   logic [7:0]  rd_data = '0;
   logic        done;
   logic [2:0]  instr_len;
   logic [19:0] target;
   logic        imm_op;
   logic        err;

   always #4 clk = ~clk;

   agu_xe_top u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
      .base_reg(base_reg), .index_reg(index_reg), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .instr_len(instr_len),
      .target(target), .imm_op(imm_op), .err(err)
   );

   typedef struct packed {
      logic [2:0]  len;
      logic [19:0] ta;
      logic        imm;
      logic        er;
      logic        chk_ta;
      logic        quick;
      logic [31:0] cyc;
   } exp_t;

   exp_t  q[$];
   string tq[$];
   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   int    rd_count = 0;
   logic [19:0] exp_rd_addr = '0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic [7:0] mb(input logic [19:0] a);
      return a[7:0] * 8'd13 + a[15:8] + {4'h0, a[19:16]} + 8'h21;
   endfunction

   function automatic [19:0] word_at(input logic [19:0] a);
      logic [23:0] w;
      w = {mb(a), mb(a + 20'd1), mb(a + 20'd2)};
      return w[19:0];
   endfunction

   function automatic [31:0] f3(input logic [5:0] op, input logic [5:0] fl, input logic [11:0] d);
      return {op, fl, d, 8'h00};
   endfunction

   function automatic [31:0] f4(input logic [5:0] op, input logic [5:0] fl, input logic [19:0] a);
      return {op, fl, a};
   endfunction

   task automatic fail_line(input string msg);
      n_fail++;
      $display("FAIL %s", msg);
   endtask

   // memory responder: three bytes after each request, with a gap before the last
   initial begin
      forever begin
         @(negedge clk);
         if (rd_req) begin
            logic [19:0] a;
            a = rd_addr;
            rd_count++;
            n_chk++;
            if (a !== exp_rd_addr)
               fail_line($sformatf("R8 rd_addr actual=%h expected=%h", a, exp_rd_addr));
            @(negedge clk); rd_valid = 1'b1; rd_data = mb(a);
            @(negedge clk); rd_data = mb(a + 20'd1);
            @(negedge clk); rd_valid = 1'b0;
            @(negedge clk); rd_valid = 1'b1; rd_data = mb(a + 20'd2);
            @(negedge clk); rd_valid = 1'b0;
         end
      end
   end

   // monitor: compare each done against the head of the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            n_chk++;
            if (q.size() == 0) begin
               fail_line("R11 unexpected done actual=1 expected=0");
            end else begin
               exp_t  e;
               string t;
               e = q.pop_front();
               t = tq.pop_front();
               if (instr_len !== e.len || imm_op !== e.imm || err !== e.er ||
                   (e.chk_ta && target !== e.ta) || (e.quick && cyc != int'(e.cyc)))
                  fail_line($sformatf("%s actual len=%0d ta=%h imm=%b err=%b cyc=%0d expected len=%0d ta=%h imm=%b err=%b cyc=%0d",
                     t, instr_len, target, imm_op, err, cyc, e.len, e.ta, e.imm, e.er, e.cyc));
            end
         end
      end
   end

   task automatic apply(input string tag, input logic [31:0] ins, input logic [19:0] p,
                        input logic [23:0] b, input logic [23:0] x,
                        input logic [2:0] len, input logic [19:0] ta, input logic imm,
                        input logic er, input logic chk_ta, input logic indir,
                        input logic [19:0] rda);
      exp_t e;
      int   rc0;
      @(negedge clk);
      rc0 = rd_count;
      exp_rd_addr = rda;
      e.len = len; e.ta = ta; e.imm = imm; e.er = er; e.chk_ta = chk_ta;
      e.quick = !indir; e.cyc = 32'(cyc + 1);
      q.push_back(e);
      tq.push_back(tag);
      instr = ins; pc = p; base_reg = b; index_reg = x; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      if (!indir) begin
         n_chk++;
         if (rd_count != rc0)
            fail_line($sformatf("%s no-read reads=%0d expected=0", tag, rd_count - rc0));
      end
      // results hold after done (R11)
      n_chk++;
      if (instr_len !== len || err !== er || (chk_ta && target !== ta))
         fail_line($sformatf("R11 hold %s actual len=%0d ta=%h expected len=%0d ta=%h",
                             tag, instr_len, target, len, ta));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (done !== 1'b0 || rd_req !== 1'b0 || err !== 1'b0 || target !== '0 ||
          instr_len !== '0 || imm_op !== 1'b0)
         fail_line($sformatf("R11 reset actual done=%b rd_req=%b err=%b ta=%h len=%0d imm=%b expected all 0",
                             done, rd_req, err, target, instr_len, imm_op));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 / R2 short formats
      apply("R1 R2 one-byte C4", 32'hC4000000, 20'h00100, 24'h0, 24'h0, 3'd1, 20'h0, 0, 0, 1, 0, 0);
      apply("R1 R2 one-byte F0", 32'hF0123456, 20'h00100, 24'h0, 24'h0, 3'd1, 20'h0, 0, 0, 1, 0, 0);
      apply("R1 R2 two-byte 90", 32'h90450000, 20'h00100, 24'h0, 24'h0, 3'd2, 20'h0, 0, 0, 1, 0, 0);
      apply("R1 R2 two-byte B4", 32'hB4FFFFFF, 20'h00100, 24'h0, 24'h0, 3'd2, 20'h0, 0, 0, 1, 0, 0);
      apply("R1 R6 nibble 8 is 3-byte", f3(6'h22, 6'b110000, 12'h00A), 20'h0, 24'h0, 24'h0, 3'd3, 20'h0000A, 0, 0, 1, 0, 0);

      // R3 legacy
      apply("R3 legacy", {8'h00, 1'b0, 15'h1234, 8'h00}, 20'h0, 24'h0, 24'h0, 3'd3, 20'h01234, 0, 0, 1, 0, 0);
      apply("R3 legacy indexed", {8'h00, 1'b1, 15'h7FFF, 8'h00}, 20'h0, 24'h0, 24'h000100, 3'd3, 20'h080FF, 0, 0, 1, 0, 0);

      // R6 direct
      apply("R6 direct", f3(6'h00, 6'b110000, 12'h0AB), 20'h0, 24'h0, 24'h0, 3'd3, 20'h000AB, 0, 0, 1, 0, 0);
      apply("R6 direct indexed", f3(6'h00, 6'b111000, 12'h0AB), 20'h0, 24'h0, 24'h000005, 3'd3, 20'h000B0, 0, 0, 1, 0, 0);
      apply("R1 R6 long", f4(6'h00, 6'b110001, 20'hABCDE), 20'h0, 24'h0, 24'h0, 3'd4, 20'hABCDE, 0, 0, 1, 0, 0);
      apply("R6 long indexed", f4(6'h00, 6'b111001, 20'hABCDE), 20'h0, 24'h0, 24'h000022, 3'd4, 20'hABD00, 0, 0, 1, 0, 0);

      // R4 base relative
      apply("R4 base max disp", f3(6'h00, 6'b110100, 12'hFFF), 20'h0, 24'h012000, 24'h0, 3'd3, 20'h12FFF, 0, 0, 1, 0, 0);
      apply("R4 base indexed", f3(6'h00, 6'b111100, 12'hFFF), 20'h0, 24'h012000, 24'h000001, 3'd3, 20'h13000, 0, 0, 1, 0, 0);

      // R5 PC relative
      apply("R5 pc negative", f3(6'h00, 6'b110010, 12'hFFE), 20'h01000, 24'h0, 24'h0, 3'd3, 20'h01001, 0, 0, 1, 0, 0);
      apply("R5 pc positive max", f3(6'h00, 6'b110010, 12'h7FF), 20'h01000, 24'h0, 24'h0, 3'd3, 20'h01802, 0, 0, 1, 0, 0);
      apply("R5 pc most negative", f3(6'h00, 6'b110010, 12'h800), 20'h01000, 24'h0, 24'h0, 3'd3, 20'h00803, 0, 0, 1, 0, 0);

      // R9 wrap
      apply("R9 pc wrap", f3(6'h00, 6'b110010, 12'h010), 20'hFFFFE, 24'h0, 24'h0, 3'd3, 20'h00011, 0, 0, 1, 0, 0);
      apply("R9 base wrap", f3(6'h00, 6'b110100, 12'h002), 20'h0, 24'hFFFFFF, 24'h0, 3'd3, 20'h00001, 0, 0, 1, 0, 0);

      // R7 immediate
      apply("R7 immediate short", f3(6'h00, 6'b010000, 12'h123), 20'h0, 24'h0, 24'h0, 3'd3, 20'h00123, 1, 0, 1, 0, 0);
      apply("R7 immediate long", f4(6'h00, 6'b010001, 20'h54321), 20'h0, 24'h0, 24'h0, 3'd4, 20'h54321, 1, 0, 1, 0, 0);

      // R8 indirect
      apply("R8 indirect direct", f3(6'h00, 6'b100000, 12'h200), 20'h0, 24'h0, 24'h0, 3'd3, word_at(20'h00200), 0, 0, 1, 1, 20'h00200);
      apply("R8 indirect pc-relative", f3(6'h00, 6'b100010, 12'h010), 20'h30000, 24'h0, 24'h0, 3'd3, word_at(20'h30013), 0, 0, 1, 1, 20'h30013);
      apply("R8 R9 indirect at top", f4(6'h00, 6'b100001, 20'hFFFFF), 20'h0, 24'h0, 24'h0, 3'd4, word_at(20'hFFFFF), 0, 0, 1, 1, 20'hFFFFF);

      // R10 illegal
      apply("R10 b and p", f3(6'h00, 6'b110110, 12'h001), 20'h0, 24'h0, 24'h0, 3'd3, 20'h0, 0, 1, 0, 0, 0);
      apply("R10 index with immediate", f3(6'h00, 6'b011000, 12'h001), 20'h0, 24'h0, 24'h0, 3'd3, 20'h0, 0, 1, 0, 0, 0);
      apply("R10 index with indirect", f3(6'h00, 6'b101000, 12'h001), 20'h0, 24'h0, 24'h0, 3'd3, 20'h0, 0, 1, 0, 0, 0);
      apply("R10 long with base", f4(6'h00, 6'b110101, 20'h00001), 20'h0, 24'h0, 24'h0, 3'd4, 20'h0, 0, 1, 0, 0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule